// File: doc/BRIEF.md
# Triggered Programmable-Width One-Shot

This block is a synchronous one-shot. When the trigger input goes from low to high and the block is idle, it drives a pulse on a true output and on a complementary output. The pulse length in clock cycles is an inherent width plus a programmed address multiplied by a step size. Both the inherent width and the step size are parameters. The address is either 8 or 12 bits wide.

After each pulse comes a recovery interval of fixed length. Trigger edges that arrive during a pulse or during recovery are dropped. A stop input cuts an active pulse short, and it blocks triggers for as long as it is held high. Recovery then runs once stop is released.

The address comes in on a parallel bus and passes through an enable control:
- While the enable is high, the bus value is used directly. The bus must then stay stable for the whole pulse.
- While the enable is low, the value that was present last while the enable was high is held. The bus can then serve other traffic freely.

All pins are plain control levels. The block has no streaming data path, so no valid/ready handshake applies.

Top module: `trig_pulse_gen`

## Requirements
- R1: A pulse starts only on a trigger low-to-high transition seen at a clock edge. A trigger held high never starts a second pulse. A trigger that is already high when reset is released does not count as a transition.
- R2: An accepted transition makes `pulse_o` rise one cycle later. `pulse_o` then stays high for exactly INH + addr*INC cycles.
- R3: The ADDR_W parameter is 8 (addresses 0 to 255) or 12 (addresses 0 to 4095). The full-scale address gives the maximum width.
- R4: Trigger transitions that occur while the pulse is high are ignored. They do not restart the pulse or extend it.
- R5: After every pulse, RECOV recovery cycles follow, and a transition seen in any of them is dropped. A transition seen at the first clock edge after recovery is accepted.
- R6: `stop_i` sampled high during a pulse makes `pulse_o` low in the next cycle, ahead of the programmed width.
- R7: While `stop_i` is high, no trigger is accepted. After `stop_i` falls, RECOV recovery cycles pass before a trigger is accepted. A transition at the same clock edge as the fall of stop is dropped.
- R8: `pulse_n_o` is always the inverse of `pulse_o`. After reset, `pulse_o` is 0 and `pulse_n_o` is 1.
- R9: With `addr_en_i` high, the live `addr_i` value at the clock edge that accepts the trigger sets the width.
- R10: With `addr_en_i` low, the address last seen while `addr_en_i` was high is used. Changes on `addr_i`, whether between pulses or during a pulse, leave the width unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Trigger level; a rising transition starts a pulse |
| stop_i | input | 1 | Ends an active pulse and holds off triggers while high |
| addr_en_i | input | 1 | High: address bus transparent; low: held address used |
| addr_i | input | ADDR_W | Parallel width address |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Complementary pulse output |

## Verification
The embedded properties check the following on every cycle:
- the two outputs stay complementary;
- a stop always drops the pulse in the next cycle;
- a pulse only starts from an accepted transition;
- a pulse never ends without entering recovery;
- the held address never moves while the enable is low.

Only the bench scenarios can show the exact widths at addresses 0, 1, mid-scale and full-scale. The same applies to the recovery-boundary timing, the dropping of transitions during a pulse, during recovery and at the release of stop, and the immunity of latched mode to bus traffic.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RECOV = 2'd2
  } shot_state_e;
endpackage

// File: rtl/pgen_addr_path.sv
module pgen_addr_path #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr_o
);
  logic [ADDR_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         hold_q <= '0;
    else if (addr_en_i) hold_q <= addr_i;
  end

  assign eff_addr_o = addr_en_i ? addr_i : hold_q;

  // R10
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_en_i |=> $stable(hold_q));
endmodule

// File: rtl/pgen_edge_det.sv
module pgen_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic rise_o
);
  logic trig_q;

  // reset value 1: a level already high at reset release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b1;
    else        trig_q <= trig_i;
  end

  assign rise_o = trig_i & ~trig_q;
endmodule

// File: rtl/pgen_shot_fsm.sv
module pgen_shot_fsm
  import pgen_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int INH    = 3,
  parameter int INC    = 2,
  parameter int RECOV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] eff_addr_i,
  output logic              pulse_o,
  output logic              pulse_n_o
);
  localparam int MAXW  = INH + ((1 << ADDR_W) - 1) * INC;
  localparam int TOP   = (MAXW > RECOV) ? MAXW : RECOV;
  localparam int CNT_W = $clog2(TOP + 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(RECOV - 1);

  shot_state_e      st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             pulse_q, pulse_nq;
  logic [CNT_W-1:0] width_ld;

  assign width_ld = CNT_W'(INH) + CNT_W'(eff_addr_i) * CNT_W'(INC) - CNT_W'(1);

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (stop_i) begin
          st_nxt  = ST_RECOV;
          cnt_nxt = REC_LD;
        end else if (rise_i) begin
          st_nxt  = ST_PULSE;
          cnt_nxt = width_ld;
        end
      end
      ST_PULSE: begin
        if (stop_i || cnt_q == '0) begin
          st_nxt  = ST_RECOV;
          cnt_nxt = REC_LD;
        end else begin
          cnt_nxt = cnt_q - CNT_W'(1);
        end
      end
      ST_RECOV: begin
        if (stop_i)            cnt_nxt = REC_LD;
        else if (cnt_q == '0)  st_nxt  = ST_IDLE;
        else                   cnt_nxt = cnt_q - CNT_W'(1);
      end
      default: begin
        st_nxt  = ST_IDLE;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      pulse_q  <= 1'b0;
      pulse_nq <= 1'b1;
    end else begin
      st_q     <= st_nxt;
      cnt_q    <= cnt_nxt;
      pulse_q  <= (st_nxt == ST_PULSE);
      pulse_nq <= (st_nxt != ST_PULSE);
    end
  end

  assign pulse_o   = pulse_q;
  assign pulse_n_o = pulse_nq;

  // R8
  compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q != pulse_nq);
  // R6
  stop_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !pulse_q);
  // R2
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(rise_i && !stop_i));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PULSE && !stop_i && cnt_q != '0) |=> pulse_q);
  // R5
  recov_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_q) |-> st_q == ST_RECOV);
endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
  parameter int ADDR_W = 8,
  parameter int INH    = 3,
  parameter int INC    = 2,
  parameter int RECOV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              stop_i,
  input  logic              addr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              pulse_o,
  output logic              pulse_n_o
);
  // R3: only 8- and 12-bit addresses are supported
  generate
    if (ADDR_W != 8 && ADDR_W != 12) begin : g_bad_width
      initial $fatal(1, "ADDR_W must be 8 or 12");
    end
  endgenerate

  logic              rise;
  logic [ADDR_W-1:0] eff_addr;

  pgen_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .rise_o (rise)
  );

  pgen_addr_path #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_en_i  (addr_en_i),
    .addr_i     (addr_i),
    .eff_addr_o (eff_addr)
  );

  pgen_shot_fsm #(
    .ADDR_W(ADDR_W), .INH(INH), .INC(INC), .RECOV(RECOV)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (rise),
    .stop_i     (stop_i),
    .eff_addr_i (eff_addr),
    .pulse_o    (pulse_o),
    .pulse_n_o  (pulse_n_o)
  );
endmodule

// File: tb/trig_pulse_gen_bench.sv
module trig_pulse_gen_bench;
  localparam int AW = 8;
  localparam int IH = 3;
  localparam int IC = 2;
  localparam int RC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0;
  logic stop = 1'b0;
  logic ae = 1'b1;
  logic [AW-1:0] addr = '0;
  logic pulse, pulse_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit compl_bad = 1'b0;

  always #2 clk = ~clk;

  trig_pulse_gen #(.ADDR_W(AW), .INH(IH), .INC(IC), .RECOV(RC)) u_trig_pulse_gen (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .stop_i(stop),
    .addr_en_i(ae), .addr_i(addr), .pulse_o(pulse), .pulse_n_o(pulse_n)
  );

  function automatic int exp_width(input int a);
    return IH + a * IC;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && pulse == pulse_n) compl_bad = 1'b1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // noise: 1 = toggle trigger during pulse, 2 = scramble bus during pulse
  task automatic run_pulse(input int a, input bit latched, input int noise, output int w);
    addr = AW'(a);
    ae = 1'b1;
    @(negedge clk);
    if (latched) begin
      ae = 1'b0;
      addr = AW'($urandom);
    end
    trig = 1'b1;
    @(negedge clk);
    w = 0;
    while (pulse && w < 5000) begin
      w++;
      if (noise == 1) trig = ~trig;
      if (noise == 2) addr = AW'($urandom);
      @(negedge clk);
    end
    trig = 1'b0;
    idle_wait(RC + 1);
  endtask

  int w, k, hi;

  initial begin
    void'($urandom(32'd20240611));
    trig = 1'b1;                  // held high across reset release
    idle_wait(3);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse == 1'b0 && pulse_n == 1'b1, "R8 reset state", pulse, 0);
    idle_wait(3);
    check(pulse == 1'b0, "R1 level at reset release", pulse, 0);
    trig = 1'b0;
    idle_wait(2);

    // R2 / R3 widths at corner addresses
    run_pulse(0, 1'b0, 0, w);   check(w == exp_width(0),   "R2 addr 0", w, exp_width(0));
    run_pulse(1, 1'b0, 0, w);   check(w == exp_width(1),   "R2 addr 1", w, exp_width(1));
    run_pulse(128, 1'b0, 0, w); check(w == exp_width(128), "R2 mid-scale", w, exp_width(128));
    run_pulse(255, 1'b0, 0, w); check(w == exp_width(255), "R3 full-scale", w, exp_width(255));

    // R4 retriggers during pulse
    run_pulse(20, 1'b0, 1, w);  check(w == exp_width(20), "R4 retrigger in pulse", w, exp_width(20));

    // R10 latched with bus noise between and during pulse
    run_pulse(37, 1'b1, 2, w);  check(w == exp_width(37), "R10 latched bus noise", w, exp_width(37));
    // R9 transparent: new bus value applies
    run_pulse(9, 1'b0, 0, w);   check(w == exp_width(9), "R9 transparent update", w, exp_width(9));

    // R1 level held high does not retrigger
    addr = AW'(2); ae = 1'b1;
    @(negedge clk); trig = 1'b1;
    idle_wait(exp_width(2) + RC + 10);
    hi = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (pulse) hi++; end
    check(hi == 0, "R1 held level no second pulse", hi, 0);
    trig = 1'b0; idle_wait(2);

    // R5 edge in last recovery cycle dropped, first idle cycle accepted
    addr = AW'(1);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    while (pulse) @(negedge clk);
    idle_wait(RC - 1);
    trig = 1'b1;
    hi = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (pulse) hi++; end
    check(hi == 0, "R5 edge in recovery dropped", hi, 0);
    trig = 1'b0; idle_wait(RC + 2);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    while (pulse) @(negedge clk);
    idle_wait(RC);
    trig = 1'b1;
    @(negedge clk);
    check(pulse == 1'b1, "R5 edge after recovery accepted", pulse, 1);
    trig = 1'b0;
    while (pulse) @(negedge clk);
    idle_wait(RC + 1);

    // R6 early stop
    addr = AW'(50);
    @(negedge clk); trig = 1'b1;
    @(negedge clk);
    k = 0;
    while (k < 7) begin k++; @(negedge clk); end
    stop = 1'b1;
    @(negedge clk);
    check(pulse == 1'b0, "R6 stop ends pulse", pulse, 0);
    // R7 edges during stop and at its release dropped
    trig = 1'b0; @(negedge clk); trig = 1'b1;
    idle_wait(3);
    check(pulse == 1'b0, "R7 trigger blocked during stop", pulse, 0);
    trig = 1'b0; @(negedge clk);
    stop = 1'b0; trig = 1'b1;
    hi = 0;
    for (int i = 0; i < RC + 6; i++) begin @(negedge clk); if (pulse) hi++; end
    check(hi == 0, "R7 edge at stop release dropped", hi, 0);
    trig = 1'b0; idle_wait(RC + 1);
    run_pulse(5, 1'b0, 0, w);   check(w == exp_width(5), "R7 normal after stop", w, exp_width(5));

    // random mix
    for (int n = 0; n < 16; n++) begin
      int a;
      bit lt;
      int nz;
      a  = int'($urandom_range(0, 255));
      lt = 1'($urandom_range(0, 1));
      nz = lt ? 2 : int'($urandom_range(0, 1));
      run_pulse(a, lt, nz, w);
      check(w == exp_width(a), lt ? "R10 random latched" : "R2 random transparent", w, exp_width(a));
    end

    check(!compl_bad, "R8 outputs complementary", compl_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule